// File: doc/BRIEF.md
# Rotating Register Window Controller

This block owns a physical register file of `NAREG` words and presents software with a sliding view of sixteen of them. The view begins at group `win_base` (one group is four registers) and wraps around the end of the file. A bitmap, `win_start`, holds one bit for each group and marks the groups where a live call frame begins. The block carries out window commands: entering a called function, returning from it, rotating the view, loading the base directly, probing for overflow before a frame is used, checking a stack-pointer move, and restoring a saved base.

Each command is accepted in one cycle. Its result appears one cycle later as a status code and a program-counter value. When a return finds its caller's frame spilled, or a probe finds a live frame in the way, the block moves the view to the frame that needs service. It records the previous base in `saved_base` and raises `exc_mode`. Moving data between registers and memory is left to the handler that software runs for that status. A host port reads any register in the current window and writes any register in it. A command never back-pressures: `cmd_ready` is low only while reset is applied and in the first cycle after it.

Top module: `rwin_ctrl`

## Requirements
- R1: After reset the base is 0, the frame bitmap holds only bit 0, the saved base is 0, `exc_mode` is 0, `rsp_valid` is 0, every register reads 0, and `cmd_ready` is 1 from the second cycle after reset onwards.
- R2: Window register r (0..15) is physical register (4·base + r) mod NAREG, for host reads and for host writes. A host write is dropped in a cycle where a command is accepted.
- R3: A command is accepted on a rising edge with `cmd_valid` and `cmd_ready` both high. Opcodes: 0 entry, 1 return, 2 rotate, 3 set base, 4 overflow probe, 5 stack-pointer move, 6 restore, 7 no-op. The state updates on that edge, and `rsp_valid` is high for exactly the following cycle. With no accepted command, base and bitmap hold.
- R4: Entry with increment c = `cmd_callinc` and source s writes a[s] − `cmd_imm` into window register 4c + (s mod 4) of the old window, then advances the base by c and sets the bitmap bit of the new base.
- R5: A return takes n = a0[31:30]. On success `rsp_pc` is {`cmd_pc`[31:30], a0[29:0]}, the bitmap bit of the old base clears, and the base moves back by n. Every other command echoes `cmd_pc` on `rsp_pc`.
- R6: A return is illegal (status 7, no state change) when n = 0, or when the nearest set bitmap bit among base−1, base−2 and base−3 lies at a distance m that is nonzero and differs from n.
- R7: A legal return whose bitmap bit at base−n is clear underflows. The base moves back by n, the old base is saved, `exc_mode` is set, and the status is 4, 5 or 6 for n = 1, 2 or 3.
- R8: An overflow probe with need w = `cmd_callinc` finds the smallest d in 1..G whose bitmap bit at base+d (mod G) is set. If d ≤ w the base moves forward by d, the old base is saved and `exc_mode` is set. The status is 1, 2 or 3 when the next set bit after that frame lies 1, 2 or 3-or-more groups further on. Otherwise the status is 0 and nothing changes.
- R9: Rotate adds `cmd_imm`[3:0], read as a signed value, to the base modulo G. Set base loads `cmd_imm` mod G.
- R10: A stack-pointer move returns status 8 when the bitmap bits at base−1, base−2 and base−3 are all clear, and status 0 otherwise. It changes no state.
- R11: Restore loads the base from the saved base and clears `exc_mode`.
- R12: The register file is written by a command only when its status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command may be accepted |
| cmd_op | input | 3 | Opcode (R3) |
| cmd_callinc | input | 2 | Call increment / probe need |
| cmd_sreg | input | 4 | Entry source register |
| cmd_imm | input | DW | Immediate / rotate amount / base value |
| cmd_pc | input | DW | Program counter of the command |
| host_we | input | 1 | Host register write |
| host_widx | input | 4 | Host write window index |
| host_wdata | input | DW | Host write data |
| host_ridx | input | 4 | Host read window index |
| host_rdata | output | DW | Host read data |
| rsp_valid | output | 1 | Result valid |
| rsp_status | output | 4 | Result status |
| rsp_pc | output | DW | Return address or echoed PC |
| win_base | output | log2(NAREG/4) | Current base group |
| win_start | output | NAREG/4 | Frame bitmap |
| saved_base | output | log2(NAREG/4) | Base saved by the last trap |
| exc_mode | output | 1 | Trap-in-progress flag |

## Verification
The bench sweeps every base with every window index, and every base with every signed rotate amount. Any mapping that fails to wrap, or a rotate that does not sign-extend, therefore gives wrong read-back data or a wrong base. Directed returns target the distance test: a design that compares m with n the wrong way, or tests the bitmap bit at base+n, either reports illegal for good returns or lets bad returns through and corrupts the base. The overflow probes place frames so that the search wraps past group G−1 and so that each gap class occurs; a search in the wrong direction or a gap that is off by one shows up as the wrong status. A long pseudo-random command stream then checks the status, the base, the bitmap and the register contents against an arithmetic model after every command.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  typedef enum logic [2:0] {
    OP_ENTRY   = 3'd0,
    OP_RETURN  = 3'd1,
    OP_ROTATE  = 3'd2,
    OP_SETBASE = 3'd3,
    OP_OVCHECK = 3'd4,
    OP_MOVSP   = 3'd5,
    OP_RESTORE = 3'd6,
    OP_NOP     = 3'd7
  } win_op_e;

  typedef enum logic [3:0] {
    ST_OK      = 4'd0,
    ST_OV4     = 4'd1,
    ST_OV8     = 4'd2,
    ST_OV12    = 4'd3,
    ST_UF4     = 4'd4,
    ST_UF8     = 4'd5,
    ST_UF12    = 4'd6,
    ST_ILLEGAL = 4'd7,
    ST_ALLOCA  = 4'd8
  } win_st_e;
endpackage

// File: rtl/rwin_regfile.sv
module rwin_regfile #(
  parameter int NAREG = 32,
  parameter int DW    = 32,
  parameter int NRD   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(NAREG/4)-1:0] base,
  input  logic [NRD*4-1:0]          rd_idx,
  output logic [NRD*DW-1:0]         rd_data,
  input  logic                      we,
  input  logic [3:0]                wr_idx,
  input  logic [DW-1:0]             wr_data
);
  localparam int PW = $clog2(NAREG);

  logic [DW-1:0] mem [NAREG];
  logic [PW-1:0] wr_phys;

  // window index -> physical index, wrapping on the file size
  assign wr_phys = {base, 2'b00} + PW'(wr_idx);

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rd
      logic [PW-1:0] rd_phys;
      assign rd_phys = {base, 2'b00} + PW'(rd_idx[p*4 +: 4]);
      assign rd_data[p*DW +: DW] = mem[rd_phys];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NAREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wr_phys] <= wr_data;
    end
  end
endmodule

// File: rtl/rwin_scan.sv
module rwin_scan #(
  parameter int G = 8
) (
  input  logic [G-1:0]          ws,
  input  logic [$clog2(G)-1:0]  base,
  input  logic [1:0]            ret_n,
  input  logic [1:0]            need,
  output logic [1:0]            near_m,
  output logic                  ret_live,
  output logic [$clog2(G):0]    ov_dist,
  output logic                  ov_hit,
  output logic [1:0]            ov_cls
);
  localparam int GW = $clog2(G);

  logic [GW-1:0] frame;
  int            gap;

  // nearest live frame below the base, within three groups
  always_comb begin
    near_m = 2'd0;
    for (int k = 3; k >= 1; k--) begin
      if (ws[base - GW'(k)]) near_m = 2'(k);
    end
  end

  assign ret_live = ws[base - GW'(ret_n)];

  // first live frame above the base (circular), then the gap beyond it
  always_comb begin
    ov_dist = (GW+1)'(G);
    for (int k = G; k >= 1; k--) begin
      if (ws[GW'(base + GW'(k))]) ov_dist = (GW+1)'(k);
    end
    frame = base + GW'(ov_dist);
    gap = G;
    for (int j = G; j >= 1; j--) begin
      if (ws[GW'(frame + GW'(j))]) gap = j;
    end
    ov_cls = (gap == 1) ? 2'd0 : (gap == 2) ? 2'd1 : 2'd2;
  end

  assign ov_hit = ov_dist <= (GW+1)'(need);
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl #(
  parameter int NAREG = 32,
  parameter int DW    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [2:0]                  cmd_op,
  input  logic [1:0]                  cmd_callinc,
  input  logic [3:0]                  cmd_sreg,
  input  logic [DW-1:0]               cmd_imm,
  input  logic [DW-1:0]               cmd_pc,
  input  logic                        host_we,
  input  logic [3:0]                  host_widx,
  input  logic [DW-1:0]               host_wdata,
  input  logic [3:0]                  host_ridx,
  output logic [DW-1:0]               host_rdata,
  output logic                        rsp_valid,
  output logic [3:0]                  rsp_status,
  output logic [DW-1:0]               rsp_pc,
  output logic [$clog2(NAREG/4)-1:0]  win_base,
  output logic [NAREG/4-1:0]          win_start,
  output logic [$clog2(NAREG/4)-1:0]  saved_base,
  output logic                        exc_mode
);
  import rwin_pkg::*;

  localparam int G  = NAREG / 4;
  localparam int GW = $clog2(G);

  logic [GW-1:0] base_q, base_d, owb_q, owb_d;
  logic [G-1:0]  ws_q, ws_d;
  logic          excm_q, excm_d, ready_q, fire;
  win_st_e       st;
  logic [DW-1:0] pc_d;

  logic          rf_we;
  logic [3:0]    rf_widx;
  logic [DW-1:0] rf_wdata;
  logic [3*DW-1:0] rd_bus;
  logic [DW-1:0] a_src, a0;
  logic [1:0]    ret_n, near_m, ov_cls;
  logic          ret_live, ov_hit;
  logic [GW:0]   ov_dist;
  logic [GW+3:0] rot;

  assign fire  = cmd_valid && ready_q;
  assign ret_n = a0[DW-1:DW-2];
  assign rot   = {{GW{cmd_imm[3]}}, cmd_imm[3:0]};

  rwin_regfile #(.NAREG(NAREG), .DW(DW), .NRD(3)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .base    (base_q),
    .rd_idx  ({4'd0, cmd_sreg, host_ridx}),
    .rd_data (rd_bus),
    .we      (rf_we),
    .wr_idx  (rf_widx),
    .wr_data (rf_wdata)
  );

  assign host_rdata = rd_bus[0*DW +: DW];
  assign a_src      = rd_bus[1*DW +: DW];
  assign a0         = rd_bus[2*DW +: DW];

  rwin_scan #(.G(G)) u_scan (
    .ws       (ws_q),
    .base     (base_q),
    .ret_n    (ret_n),
    .need     (cmd_callinc),
    .near_m   (near_m),
    .ret_live (ret_live),
    .ov_dist  (ov_dist),
    .ov_hit   (ov_hit),
    .ov_cls   (ov_cls)
  );

  always_comb begin
    base_d   = base_q;
    ws_d     = ws_q;
    owb_d    = owb_q;
    excm_d   = excm_q;
    st       = ST_OK;
    pc_d     = cmd_pc;
    rf_we    = host_we && !fire;
    rf_widx  = host_widx;
    rf_wdata = host_wdata;
    if (fire) begin
      case (win_op_e'(cmd_op))
        OP_ENTRY: begin
          rf_we    = 1'b1;
          rf_widx  = {cmd_callinc, cmd_sreg[1:0]};
          rf_wdata = a_src - cmd_imm;
          base_d   = base_q + GW'(cmd_callinc);
          ws_d     = ws_q | (G'(1) << base_d);
        end
        OP_RETURN: begin
          if (ret_n == 2'd0 || (near_m != 2'd0 && near_m != ret_n)) begin
            st = ST_ILLEGAL;
          end else if (!ret_live) begin
            owb_d  = base_q;
            base_d = base_q - GW'(ret_n);
            excm_d = 1'b1;
            case (ret_n)
              2'd1:    st = ST_UF4;
              2'd2:    st = ST_UF8;
              default: st = ST_UF12;
            endcase
          end else begin
            pc_d   = {cmd_pc[DW-1:DW-2], a0[DW-3:0]};
            ws_d   = ws_q & ~(G'(1) << base_q);
            base_d = base_q - GW'(ret_n);
          end
        end
        OP_ROTATE:  base_d = base_q + rot[GW-1:0];
        OP_SETBASE: base_d = cmd_imm[GW-1:0];
        OP_OVCHECK: begin
          if (ov_hit) begin
            owb_d  = base_q;
            base_d = base_q + GW'(ov_dist);
            excm_d = 1'b1;
            case (ov_cls)
              2'd0:    st = ST_OV4;
              2'd1:    st = ST_OV8;
              default: st = ST_OV12;
            endcase
          end
        end
        OP_MOVSP: begin
          if (near_m == 2'd0) st = ST_ALLOCA;
        end
        OP_RESTORE: begin
          base_d = owb_q;
          excm_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      ws_q       <= G'(1);
      owb_q      <= '0;
      excm_q     <= 1'b0;
      ready_q    <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_status <= 4'd0;
      rsp_pc     <= '0;
    end else begin
      base_q     <= base_d;
      ws_q       <= ws_d;
      owb_q      <= owb_d;
      excm_q     <= excm_d;
      ready_q    <= 1'b1;
      rsp_valid  <= fire;
      rsp_status <= st;
      rsp_pc     <= pc_d;
    end
  end

  assign cmd_ready  = ready_q;
  assign win_base   = base_q;
  assign win_start  = ws_q;
  assign saved_base = owb_q;
  assign exc_mode   = excm_q;
endmodule

// File: rtl/rwin_ctrl_chk.sv
module rwin_ctrl_chk #(
  parameter int NAREG = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cmd_valid,
  input logic                        cmd_ready,
  input logic [2:0]                  cmd_op,
  input logic                        rsp_valid,
  input logic [3:0]                  rsp_status,
  input logic [$clog2(NAREG/4)-1:0]  win_base,
  input logic [NAREG/4-1:0]          win_start,
  input logic [$clog2(NAREG/4)-1:0]  saved_base,
  input logic                        exc_mode
);
  logic fire;
  assign fire = cmd_valid && cmd_ready;

  AST_RSP_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n) fire |=> rsp_valid); // R3
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !fire |=> !rsp_valid); // R3
  AST_STATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !fire |=> ($stable(win_base) && $stable(win_start))); // R3
  AST_ENTRY_MARK: assert property (@(posedge clk) disable iff (!rst_n) (fire && cmd_op == 3'd0) |=> win_start[win_base]); // R4
  AST_START_LIVE: assert property (@(posedge clk) disable iff (!rst_n) win_start != '0); // R5
  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && (rsp_status == 4'd7 || rsp_status == 4'd8)) |-> ($stable(win_base) && $stable(win_start))); // R6
  AST_TRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_status >= 4'd1 && rsp_status <= 4'd6) |-> exc_mode); // R7
  AST_RESTORE_BASE: assert property (@(posedge clk) disable iff (!rst_n) (fire && cmd_op == 3'd6) |=> (!exc_mode && win_base == $past(saved_base))); // R11
endmodule

bind rwin_ctrl rwin_ctrl_chk #(.NAREG(NAREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .win_base   (win_base),
  .win_start  (win_start),
  .saved_base (saved_base),
  .exc_mode   (exc_mode)
);

// File: tb/sim_rwin_ctrl.sv
module sim_rwin_ctrl;
  localparam int NAREG = 32;
  localparam int DW    = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_callinc;
  logic [3:0]  cmd_sreg;
  logic [31:0] cmd_imm, cmd_pc;
  logic        host_we;
  logic [3:0]  host_widx, host_ridx;
  logic [31:0] host_wdata, host_rdata;
  logic        rsp_valid;
  logic [3:0]  rsp_status;
  logic [31:0] rsp_pc;
  logic [2:0]  win_base, saved_base;
  logic [7:0]  win_start;
  logic        exc_mode;

  always #5 clk = ~clk;

  rwin_ctrl #(.NAREG(NAREG), .DW(DW)) u0 (.*);

  int errs = 0;
  int checks = 0;
  logic [31:0] mrf [32];
  int          mb, mowb;
  logic [7:0]  mws;
  logic        mexc;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(req, "base", 64'(win_base), 64'(mb));
    chk(req, "bitmap", 64'(win_start), 64'(mws));
    chk(req, "saved_base", 64'(saved_base), 64'(mowb));
    chk(req, "exc_mode", 64'(exc_mode), 64'(mexc));
  endtask

  task automatic rd_chk(input string req, input int r);
    host_ridx = 4'(r);
    #1;
    chk(req, "rdata", 64'(host_rdata), 64'(mrf[5'(mb * 4 + r)]));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; host_we = 1'b0;
    cmd_op = 3'd7; cmd_callinc = 2'd0; cmd_sreg = 4'd0; cmd_imm = '0; cmd_pc = '0;
    host_widx = 4'd0; host_wdata = '0; host_ridx = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 32; i++) mrf[i] = '0;
    mb = 0; mowb = 0; mws = 8'h01; mexc = 1'b0;
  endtask

  task automatic host_wr(input int r, input logic [31:0] v);
    @(negedge clk);
    host_we = 1'b1; host_widx = 4'(r); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
    mrf[5'(mb * 4 + r)] = v;
  endtask

  task automatic do_cmd(input string req, input logic [2:0] op, input logic [1:0] ci,
                        input logic [3:0] s, input logic [31:0] imm, input logic [31:0] pc);
    logic [3:0]  est;
    logic [31:0] epc, a0, v;
    int b, n, m, k, f, j, rr;
    est = 4'd0; epc = pc; b = mb;
    case (op)
      3'd0: begin
        v = mrf[5'(b * 4 + int'(s))] - imm;
        mrf[5'(b * 4 + int'({ci, s[1:0]}))] = v;
        mb = (b + int'(ci)) % 8;
        mws[3'(mb)] = 1'b1;
      end
      3'd1: begin
        a0 = mrf[5'(b * 4)];
        n = int'(a0[31:30]);
        m = mws[3'(b - 1)] ? 1 : mws[3'(b - 2)] ? 2 : mws[3'(b - 3)] ? 3 : 0;
        if (n == 0 || (m != 0 && m != n)) est = 4'd7;
        else if (!mws[3'(b - n)]) begin
          mowb = b; mb = (b - n + 8) % 8; mexc = 1'b1; est = 4'(3 + n);
        end else begin
          epc = {pc[31:30], a0[29:0]};
          mws[3'(b)] = 1'b0;
          mb = (b - n + 8) % 8;
        end
      end
      3'd2: begin
        rr = int'(imm[3:0]);
        if (rr >= 8) rr = rr - 16;
        mb = (b + rr + 16) % 8;
      end
      3'd3: mb = int'(imm[2:0]);
      3'd4: begin
        n = 8;
        for (k = 8; k >= 1; k--) if (mws[3'(b + k)]) n = k;
        if (n <= int'(ci)) begin
          f = b + n; j = 8;
          for (k = 8; k >= 1; k--) if (mws[3'(f + k)]) j = k;
          est = (j == 1) ? 4'd1 : (j == 2) ? 4'd2 : 4'd3;
          mowb = b; mb = (b + n) % 8; mexc = 1'b1;
        end
      end
      3'd5: begin
        if (!mws[3'(b - 1)] && !mws[3'(b - 2)] && !mws[3'(b - 3)]) est = 4'd8;
      end
      3'd6: begin mb = mowb; mexc = 1'b0; end
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_callinc = ci; cmd_sreg = s; cmd_imm = imm; cmd_pc = pc;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(req, "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(req, "status", 64'(rsp_status), 64'(est));
    chk(req, "rsp_pc", 64'(rsp_pc), 64'(epc));
    check_state(req);
  endtask

  initial begin
    #2000000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1", "cmd_ready", 64'(cmd_ready), 64'd1);
    check_state("R1");
    for (int r = 0; r < 16; r++) rd_chk("R1", r);

    // R2 mapping sweep over every base and index
    do_cmd("R9", 3'd3, 2'd0, 4'd0, 32'd0, 32'h0);
    for (int r = 0; r < 16; r++) host_wr(r, 32'hA000 + 32'(r));
    do_cmd("R9", 3'd3, 2'd0, 4'd0, 32'd4, 32'h0);
    for (int r = 0; r < 16; r++) host_wr(r, 32'hA010 + 32'(r));
    for (int b = 0; b < 8; b++) begin
      do_cmd("R9", 3'd3, 2'd0, 4'd0, 32'(b), 32'h0);
      for (int r = 0; r < 16; r++) rd_chk("R2", r);
    end
    // R2 host write dropped while a command is accepted
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd7; host_we = 1'b1; host_widx = 4'd0; host_wdata = 32'hDEAD;
    @(negedge clk);
    cmd_valid = 1'b0; host_we = 1'b0;
    chk("R3", "nop status", 64'(rsp_status), 64'd0);
    rd_chk("R2", 0);

    // R9 rotate sweep
    for (int b = 0; b < 8; b++)
      for (int i = 0; i < 16; i++) begin
        do_cmd("R9", 3'd3, 2'd0, 4'd0, 32'(b), 32'h0);
        do_cmd("R9", 3'd2, 2'd0, 4'd0, 32'(i), 32'h0);
      end

    // R4 / R5 entry and return for each increment
    for (int c = 1; c < 4; c++) begin
      do_reset();
      host_wr(1, 32'd1000 + 32'(c));
      do_cmd("R4", 3'd0, 2'(c), 4'd5, 32'd16, 32'h0);
      for (int r = 0; r < 16; r++) rd_chk("R4", r);
      host_wr(0, {2'(c), 30'h0123_4567});
      do_cmd("R5", 3'd1, 2'd0, 4'd0, 32'd0, 32'hC000_0000);
      rd_chk("R12", 4 * c + 1);
    end

    // R6 illegal returns
    do_reset();
    host_wr(0, 32'h0000_0010);
    do_cmd("R6", 3'd1, 2'd0, 4'd0, 32'd0, 32'h4000_0000);
    do_cmd("R4", 3'd0, 2'd2, 4'd0, 32'd0, 32'h0);
    host_wr(0, 32'h4000_0010);
    do_cmd("R6", 3'd1, 2'd0, 4'd0, 32'd0, 32'h0);
    host_wr(0, 32'hC000_0010);
    do_cmd("R6", 3'd1, 2'd0, 4'd0, 32'd0, 32'h0);

    // R7 underflow for each frame size, R11 restore
    for (int n = 1; n < 4; n++) begin
      do_reset();
      host_wr(0, {2'(n), 30'h55});
      do_cmd("R7", 3'd1, 2'd0, 4'd0, 32'd0, 32'h8000_0000);
      do_cmd("R11", 3'd6, 2'd0, 4'd0, 32'd0, 32'h0);
    end

    // R8 overflow probes
    do_reset();
    do_cmd("R8", 3'd4, 2'd3, 4'd0, 32'd0, 32'h0);
    do_cmd("R4", 3'd0, 2'd3, 4'd0, 32'd0, 32'h0);
    do_cmd("R4", 3'd0, 2'd3, 4'd0, 32'd0, 32'h0);
    do_cmd("R8", 3'd4, 2'd1, 4'd0, 32'd0, 32'h0);
    do_cmd("R8", 3'd4, 2'd2, 4'd0, 32'd0, 32'h0);
    do_cmd("R11", 3'd6, 2'd0, 4'd0, 32'd0, 32'h0);
    do_reset();
    do_cmd("R4", 3'd0, 2'd1, 4'd0, 32'd0, 32'h0);
    do_cmd("R4", 3'd0, 2'd1, 4'd0, 32'd0, 32'h0);
    do_cmd("R9", 3'd2, 2'd0, 4'd0, 32'd13, 32'h0);
    do_cmd("R8", 3'd4, 2'd1, 4'd0, 32'd0, 32'h0);
    do_reset();
    do_cmd("R4", 3'd0, 2'd2, 4'd0, 32'd0, 32'h0);
    do_cmd("R4", 3'd0, 2'd2, 4'd0, 32'd0, 32'h0);
    do_cmd("R9", 3'd3, 2'd0, 4'd0, 32'd7, 32'h0);
    do_cmd("R8", 3'd4, 2'd1, 4'd0, 32'd0, 32'h0);

    // R10 stack-pointer move
    do_reset();
    do_cmd("R10", 3'd5, 2'd0, 4'd0, 32'd0, 32'h0);
    do_cmd("R4", 3'd0, 2'd1, 4'd0, 32'd0, 32'h0);
    do_cmd("R10", 3'd5, 2'd0, 4'd0, 32'd0, 32'h0);

    // R12 and all others: pseudo-random command stream against the model
    do_reset();
    for (int it = 0; it < 600; it++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      if (op == 3'd1) host_wr(0, $urandom());
      else if ($urandom_range(0, 3) == 0) host_wr(int'($urandom_range(0, 15)), $urandom());
      do_cmd("R12", op, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)),
             32'($urandom_range(0, 255)), $urandom());
      rd_chk("R12", int'($urandom_range(0, 15)));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule